// File: doc/BRIEF.md
# Codec Clock-Mode and Auto Power-Down Controller

This block sets the operating state of a voice codec from four slow, asynchronous inputs: a pin that carries either the receive master clock or a static power-down level, a pin that carries either the receive bit clock or a static clock-select level, and the transmit and receive frame syncs. It runs on a free-running reference clock that is much faster than any of these pins. For each dual-purpose pin it decides whether a clock is running or the pin is held at a level. From that it reports whether the transmit master clock and the transmit bit clock must serve both directions, and which master-clock divider family to use.

It also asks for power-down. A static high on the master-clock pin always powers the device down. Independently, an idle timer powers the device down when no frame-sync rising edge has been seen for a set number of reference cycles. Any frame-sync rising edge in either direction wakes the device. After a wake-up, the transmit data driver stays in high impedance until the second transmit frame sync. The analog circuits, the PLL and the dividers themselves lie outside this block.

Top module: `codec_clk_pwr_ctrl`

## Requirements
- R1: Reset is synchronous and active low. After reset, `pwr_down_o`=1, `tx_drive_en_o`=0, `mclk_shared_o`=0, `bclk_shared_o`=1 and `sel_2048_o`=1. The master-clock pin is taken as static high and the clock-select pin as static low.
- R2: A dual-purpose pin is classed as clocked 3 reference cycles after any transition on it. It is classed as static, at its sampled level, once WINDOW_CYCLES cycles pass without a transition, which is WINDOW_CYCLES+3 cycles after its last transition.
- R3: While the master-clock pin is static low, `mclk_shared_o`=1. That static low does not itself request power-down.
- R4: While the master-clock pin is static high, `pwr_down_o`=1 even with frame syncs running. While that pin is clocked, `mclk_shared_o`=0 and the pin does not request power-down.
- R5: While the clock-select pin is static, `bclk_shared_o`=1 and `sel_2048_o` = NOT level. Level 0 selects the 2.048 MHz divider (`sel_2048_o`=1). Level 1 selects the 1.536/1.544 MHz divider (`sel_2048_o`=0).
- R6: While the clock-select pin is clocked, `bclk_shared_o`=0 and `sel_2048_o` keeps the value latched during the last static period.
- R7: A rising edge on either frame sync clears the idle power-down 3 reference cycles after the edge reaches the pin.
- R8: With no frame-sync rising edge for IDLE_CYCLES cycles, `pwr_down_o` rises IDLE_CYCLES+3 cycles after the last rising edge. Every rising edge restarts the count, so frames that arrive more often than that keep the device up.
- R9: `tx_drive_en_o` is 0 while powered down and after the first transmit frame sync of a power-up. It rises 3 cycles after the second transmit frame-sync rising edge. A transmit frame sync that causes the wake-up counts as the first. A receive frame sync does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk_pdn_i | input | 1 | Receive master clock, or static power-down level (high = down) |
| bclk_sel_i | input | 1 | Receive bit clock, or static divider-select level |
| fs_tx_i | input | 1 | Transmit frame sync |
| fs_rx_i | input | 1 | Receive frame sync |
| pwr_down_o | output | 1 | Power-down request |
| mclk_shared_o | output | 1 | Transmit master clock drives both directions |
| bclk_shared_o | output | 1 | Transmit bit clock drives both directions |
| sel_2048_o | output | 1 | 1 = 2.048 MHz divider, 0 = 1.536/1.544 MHz divider |
| tx_drive_en_o | output | 1 | Transmit data driver may leave high impedance |

## Verification
Every input passes two synchronizer flops and one edge-detect flop. A pin change made just after a falling edge therefore shows at the outputs after the third rising edge. The bench samples on falling edges, so it expects each result at the third falling edge after the stimulus. Static classification is due at falling edge WINDOW_CYCLES+3, and idle power-down at falling edge IDLE_CYCLES+3. For the R2, R7, R8 and R9 boundaries the bench checks both the falling edge one before the due point and the due point itself, so a one-cycle shift in either direction is reported. Steady-state conditions, such as staying up under periodic frames, are checked on every cycle of the interval and reported as one result.

// File: rtl/codec_clkpwr_pkg.sv
// Shared types for the codec clock-mode / power-down controller.
package codec_clkpwr_pkg;

    // Progress of the transmit driver gate after a power-up.
    typedef enum logic [1:0] {
        TXG_OFF = 2'd0,   // no transmit frame seen yet
        TXG_ONE = 2'd1,   // first transmit frame seen
        TXG_ON  = 2'd2    // second frame seen: driver allowed
    } txg_state_t;

endpackage

// File: rtl/pin_activity_classifier.sv
// Classifies a slow asynchronous pin as "clocked" or "static at a level".
// Assumes: the pin toggles far more often than once per WINDOW_CYCLES
// reference cycles when it carries a clock. The level is latched only
// while the pin is static and is held while it is clocked.
module pin_activity_classifier #(
    parameter int   WINDOW_CYCLES = 64,
    parameter int   SYNC_STAGES   = 2,
    parameter logic RESET_LEVEL   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic clocked_o,
    output logic level_o
);
    localparam int CW = $clog2(WINDOW_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic          prev_q;
    logic [CW-1:0] quiet_cnt_q;
    logic          clocked_q;
    logic          level_q;
    logic          edge_w;

    // Synchronizer chain, one flop per stage.
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // Purpose: capture the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= RESET_LEVEL;
                    else        sync_q[0] <= pin_i;
                end
            end else begin : g_next
                // Purpose: further metastability settling.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= RESET_LEVEL;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign edge_w = sync_q[SYNC_STAGES-1] ^ prev_q;

    // Purpose: count quiet cycles and decide clocked vs static.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q      <= RESET_LEVEL;
            quiet_cnt_q <= '0;
            clocked_q   <= 1'b0;
            level_q     <= RESET_LEVEL;
        end else begin
            prev_q <= sync_q[SYNC_STAGES-1];
            if (edge_w) begin
                quiet_cnt_q <= '0;
                clocked_q   <= 1'b1;
            end else if (quiet_cnt_q == LAST) begin
                clocked_q <= 1'b0;
                level_q   <= sync_q[SYNC_STAGES-1];
            end else begin
                quiet_cnt_q <= quiet_cnt_q + 1'b1;
            end
        end
    end

    assign clocked_o = clocked_q;
    assign level_o   = level_q;

    // R2
    toggle_marks_clocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_w |=> clocked_q);

    // R6
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clocked_q |=> (!clocked_q || $stable(level_q)));

endmodule

// File: rtl/frame_idle_timer.sv
// Watches both frame syncs. Any rising edge wakes the device; IDLE_CYCLES
// reference cycles without one put it to sleep. Starts asleep after reset.
// Assumes frame-sync pulses last at least one reference cycle.
module frame_idle_timer #(
    parameter int IDLE_CYCLES = 200000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_tx_i,
    input  logic fs_rx_i,
    output logic asleep_o,
    output logic fsx_rise_o
);
    localparam int IW = $clog2(IDLE_CYCLES + 1);
    localparam logic [IW-1:0] LAST = IW'(IDLE_CYCLES - 1);

    logic [1:0]    stage_q [SYNC_STAGES];
    logic [1:0]    prev_q;
    logic [1:0]    rise_w;
    logic [IW-1:0] idle_cnt_q;
    logic          asleep_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // Purpose: capture both frame syncs ({rx, tx}).
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= 2'b00;
                    else        stage_q[0] <= {fs_rx_i, fs_tx_i};
                end
            end else begin : g_next
                // Purpose: further metastability settling.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= 2'b00;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign rise_w     = stage_q[SYNC_STAGES-1] & ~prev_q;
    assign fsx_rise_o = rise_w[0];

    // Purpose: inactivity count and sleep/wake state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q     <= 2'b00;
            idle_cnt_q <= '0;
            asleep_q   <= 1'b1;
        end else begin
            prev_q <= stage_q[SYNC_STAGES-1];
            if (|rise_w) begin
                idle_cnt_q <= '0;
                asleep_q   <= 1'b0;
            end else if (!asleep_q) begin
                if (idle_cnt_q == LAST) asleep_q   <= 1'b1;
                else                    idle_cnt_q <= idle_cnt_q + 1'b1;
            end
        end
    end

    assign asleep_o = asleep_q;

    // R7
    wake_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_w) |=> !asleep_q);

    // R8
    sleep_needs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep_q) |-> !$past(|rise_w));

    // R8
    stay_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep_q && !(|rise_w)) |=> asleep_q);

endmodule

// File: rtl/tx_slot_gate.sv
// Keeps the transmit data driver off after a power-up until the second
// transmit frame sync. A transmit frame that arrives while the device is
// still down (the waking one) counts as the first.
module tx_slot_gate
    import codec_clkpwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down_i,
    input  logic fsx_rise_i,
    output logic tx_en_o
);
    txg_state_t st_q;

    // Purpose: count transmit frames since the last power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= TXG_OFF;
        end else if (pwr_down_i) begin
            st_q <= fsx_rise_i ? TXG_ONE : TXG_OFF;
        end else if (fsx_rise_i) begin
            st_q <= (st_q == TXG_OFF) ? TXG_ONE : TXG_ON;
        end
    end

    assign tx_en_o = (st_q == TXG_ON) && !pwr_down_i;

    // R9
    tx_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en_o) |-> $past(fsx_rise_i));

endmodule

// File: rtl/codec_clk_pwr_ctrl.sv
// Top: derives clocking mode, divider choice and power-down request for a
// codec from two dual-purpose pins and the two frame syncs.
// Assumes the reference clock is much faster than every pin it watches.
module codec_clk_pwr_ctrl #(
    parameter int WINDOW_CYCLES = 64,
    parameter int IDLE_CYCLES   = 200000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mclk_pdn_i,
    input  logic bclk_sel_i,
    input  logic fs_tx_i,
    input  logic fs_rx_i,
    output logic pwr_down_o,
    output logic mclk_shared_o,
    output logic bclk_shared_o,
    output logic sel_2048_o,
    output logic tx_drive_en_o
);
    logic mclk_clocked, mclk_level;
    logic bclk_clocked, bclk_level;
    logic asleep, fsx_rise;
    logic pd_w;

    pin_activity_classifier #(
        .WINDOW_CYCLES(WINDOW_CYCLES), .SYNC_STAGES(SYNC_STAGES), .RESET_LEVEL(1'b1)
    ) u_mclk_cls (
        .clk(clk), .rst_n(rst_n), .pin_i(mclk_pdn_i),
        .clocked_o(mclk_clocked), .level_o(mclk_level)
    );

    pin_activity_classifier #(
        .WINDOW_CYCLES(WINDOW_CYCLES), .SYNC_STAGES(SYNC_STAGES), .RESET_LEVEL(1'b0)
    ) u_bclk_cls (
        .clk(clk), .rst_n(rst_n), .pin_i(bclk_sel_i),
        .clocked_o(bclk_clocked), .level_o(bclk_level)
    );

    frame_idle_timer #(
        .IDLE_CYCLES(IDLE_CYCLES), .SYNC_STAGES(SYNC_STAGES)
    ) u_idle (
        .clk(clk), .rst_n(rst_n), .fs_tx_i(fs_tx_i), .fs_rx_i(fs_rx_i),
        .asleep_o(asleep), .fsx_rise_o(fsx_rise)
    );

    // Power-down: idle timeout, or master-clock pin held high.
    assign pd_w = asleep | (~mclk_clocked & mclk_level);

    tx_slot_gate u_txg (
        .clk(clk), .rst_n(rst_n), .pwr_down_i(pd_w), .fsx_rise_i(fsx_rise),
        .tx_en_o(tx_drive_en_o)
    );

    assign pwr_down_o    = pd_w;
    assign mclk_shared_o = ~mclk_clocked & ~mclk_level;
    assign bclk_shared_o = ~bclk_clocked;
    assign sel_2048_o    = ~bclk_level;

endmodule

// File: tb/tb_codec_clk_pwr_ctrl.sv
module tb_codec_clk_pwr_ctrl;
    localparam int WIN  = 16;
    localparam int IDLE = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mclk_lvl = 1'b1, mclk_run = 1'b0, mclk_gen = 1'b0;
    logic bclk_lvl = 1'b0, bclk_run = 1'b0, bclk_gen = 1'b0;
    logic fs_tx = 1'b0, fs_rx = 1'b0;
    logic mclk_pin, bclk_pin;
    logic pwr_down, mclk_shared, bclk_shared, sel_2048, tx_en;
    int   mdiv = 0, bdiv = 0;
    int   total = 0, failed = 0;
    bit   done = 0;

    always #2.5 clk = ~clk;

    assign mclk_pin = mclk_run ? mclk_gen : mclk_lvl;
    assign bclk_pin = bclk_run ? bclk_gen : bclk_lvl;

    // Pin clock generators: toggle every 3 reference cycles when running.
    always @(negedge clk) begin
        if (mclk_run) begin
            if (mdiv == 2) begin mdiv <= 0; mclk_gen <= ~mclk_gen; end
            else mdiv <= mdiv + 1;
        end
        if (bclk_run) begin
            if (bdiv == 2) begin bdiv <= 0; bclk_gen <= ~bclk_gen; end
            else bdiv <= bdiv + 1;
        end
    end

    codec_clk_pwr_ctrl #(.WINDOW_CYCLES(WIN), .IDLE_CYCLES(IDLE), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .mclk_pdn_i(mclk_pin), .bclk_sel_i(bclk_pin),
        .fs_tx_i(fs_tx), .fs_rx_i(fs_rx), .pwr_down_o(pwr_down),
        .mclk_shared_o(mclk_shared), .bclk_shared_o(bclk_shared),
        .sel_2048_o(sel_2048), .tx_drive_en_o(tx_en)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Receive frames every 150 cycles; pwr_down must equal exp_pd each cycle
    // from 3 cycles after the first rising edge.
    task automatic run_frames(input int n, input logic exp_pd, input string req);
        int bad = 0;
        for (int f = 0; f < n; f++) begin
            fs_rx = 1'b1;
            for (int c = 0; c < 150; c++) begin
                step(1);
                if (c == 1) fs_rx = 1'b0;
                if ((f > 0 || c >= 2) && pwr_down !== exp_pd) bad++;
            end
        end
        total++;
        if (bad != 0) begin
            failed++;
            $display("FAIL %s pwr_down under frames: actual %0d wrong cycles expected 0 (level %b)",
                     req, bad, exp_pd);
        end
    endtask

    task automatic t_reset;
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1", "pwr_down", pwr_down, 1'b1);
        chk("R1", "tx_en", tx_en, 1'b0);
        chk("R1", "mclk_shared", mclk_shared, 1'b0);
        chk("R1", "bclk_shared", bclk_shared, 1'b1);
        chk("R1", "sel_2048", sel_2048, 1'b1);
    endtask

    task automatic t_static_pins;
        mclk_lvl = 1'b0;
        bclk_lvl = 1'b1;
        step(WIN + 5);
        chk("R3", "mclk_shared static low", mclk_shared, 1'b1);
        chk("R5", "bclk_shared static", bclk_shared, 1'b1);
        chk("R5", "sel_2048 level 1", sel_2048, 1'b0);
        chk("R8", "still asleep without frames", pwr_down, 1'b1);
    endtask

    task automatic t_wake;
        fs_rx = 1'b1;
        step(2);
        chk("R7", "pwr_down one cycle before wake", pwr_down, 1'b1);
        step(1);
        chk("R7", "pwr_down after rx frame", pwr_down, 1'b0);
        chk("R9", "tx_en after rx-only wake", tx_en, 1'b0);
        fs_rx = 1'b0;
        step(2);
    endtask

    task automatic t_tx_gate;
        fs_tx = 1'b1;
        step(2);
        fs_tx = 1'b0;
        step(3);
        chk("R9", "tx_en after first tx frame", tx_en, 1'b0);
        fs_tx = 1'b1;
        step(2);
        chk("R9", "tx_en one cycle early", tx_en, 1'b0);
        step(1);
        chk("R9", "tx_en after second tx frame", tx_en, 1'b1);
        fs_tx = 1'b0;
        step(2);
    endtask

    task automatic t_timeout;
        fs_tx = 1'b1;
        step(2);
        fs_tx = 1'b0;
        step(IDLE);
        chk("R8", "pwr_down one cycle before timeout", pwr_down, 1'b0);
        chk("R9", "tx_en before timeout", tx_en, 1'b1);
        step(1);
        chk("R8", "pwr_down at timeout", pwr_down, 1'b1);
        chk("R9", "tx_en while down", tx_en, 1'b0);
        run_frames(6, 1'b0, "R8");
    endtask

    task automatic t_pdn_high;
        mclk_lvl = 1'b1;
        step(WIN + 5);
        chk("R4", "pwr_down static high", pwr_down, 1'b1);
        run_frames(4, 1'b1, "R4");
        chk("R4", "mclk_shared static high", mclk_shared, 1'b0);
        chk("R9", "tx_en while pin forces down", tx_en, 1'b0);
    endtask

    task automatic t_mclk_clocked;
        mclk_run = 1'b1;
        step(8);
        chk("R4", "mclk_shared when clocked", mclk_shared, 1'b0);
        run_frames(4, 1'b0, "R4");
        mclk_run = 1'b0;
        mclk_lvl = 1'b0;
        step(WIN + 5);
        chk("R3", "mclk_shared back to static low", mclk_shared, 1'b1);
        chk("R3", "static low keeps device up", pwr_down, 1'b0);
    endtask

    task automatic t_bclk;
        bclk_lvl = 1'b0;
        step(3);
        chk("R2", "bclk clocked after transition", bclk_shared, 1'b0);
        step(WIN - 1);
        chk("R2", "bclk not yet static", bclk_shared, 1'b0);
        chk("R6", "sel_2048 held before static", sel_2048, 1'b0);
        step(1);
        chk("R2", "bclk static after window", bclk_shared, 1'b1);
        chk("R5", "sel_2048 level 0", sel_2048, 1'b1);
        bclk_run = 1'b1;
        step(8);
        chk("R6", "bclk_shared when clocked", bclk_shared, 1'b0);
        step(40);
        chk("R6", "bclk stays clocked", bclk_shared, 1'b0);
        chk("R6", "sel_2048 held while clocked", sel_2048, 1'b1);
        bclk_run = 1'b0;
        bclk_lvl = 1'b1;
        step(WIN + 5);
        chk("R5", "bclk_shared static again", bclk_shared, 1'b1);
        chk("R5", "sel_2048 relatched level 1", sel_2048, 1'b0);
    endtask

    initial begin
        t_reset();
        t_static_pins();
        t_wake();
        t_tx_gate();
        t_timeout();
        t_pdn_high();
        t_mclk_clocked();
        t_bclk();
        done = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

endmodule